// File: doc/BRIEF.md
# Status-Flag Request Router

This block sits between a serial port's status-flag logic and the chip's DMA engine. Five flags come in from the flag logic: transmit buffer empty, transmission complete, receive buffer full, line idle and break detected. Each flag has its own request-enable bit and its own DMA-select bit. With both bits set, the flag is routed to a DMA request line for its channel. With only the enable bit set, the flag drives a shared interrupt line instead.

A DMA request is held until the DMA engine returns a single-cycle done pulse on that channel. That pulse clears the request and sends a clear strobe back to the flag logic. If the flag is still present in the cycle after the done pulse, the request is raised again. While the receive-full or idle flag is routed to DMA, the block drives a suppress line to the flag logic. This stops the usual status-read-then-data-read sequence from clearing that flag.

Top module: `flag_req_router`

## Requirements
- R1: When a flag is high at a clock edge and both its enable bit and its select bit are 1, its `dmaReq` bit is 1 after that edge.
- R2: A `dmaReq` bit stays 0 when its enable bit or its select bit was 0 at the preceding edge, whatever the flag does.
- R3: `irqOut` is the OR, over all flags, of flag AND enable AND NOT select, with no clock delay.
- R4: Once asserted, a `dmaReq` bit stays 1 while routing stays on and no done pulse arrives, even after the flag drops.
- R5: A done pulse on a channel with a pending request raises that channel's `flagClr` bit in the same cycle, and the request is 0 after the next edge.
- R6: A done pulse on a channel with no pending request is ignored: `flagClr` stays 0 and `dmaReq` is unchanged.
- R7: If the flag is still high in the cycle after the done pulse, the request is 1 again one edge later.
- R8: Flag bit positions are 0 = transmit empty, 1 = transmit complete, 2 = receive full, 3 = idle, 4 = break. `clrBlock` bits 2 and 3 equal enable AND select for that bit, with no clock delay. Bits 0, 1 and 4 are always 0.
- R9: Out of reset, `dmaReq` is all zero.
- R10: Clearing the enable or the select bit of a pending channel drops its request after the next edge, without a `flagClr` strobe.
- R11: When a done pulse and a high flag meet at the same edge, the request is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqEn | input | 5 | Per-flag request enable |
| dmaSel | input | 5 | Per-flag DMA select |
| flagIn | input | 5 | Flag states from the flag logic |
| dmaDone | input | 5 | Per-channel single-cycle DMA done pulse |
| dmaReq | output | 5 | Per-channel DMA request |
| irqOut | output | 1 | Combined interrupt request |
| flagClr | output | 5 | Clear strobe to the flag logic |
| clrBlock | output | 5 | Blocks the read-sequence clear of a receive flag |

## Verification
`irqOut`, `clrBlock` and `flagClr` are combinational, so they are due in the same cycle as the inputs that cause them. `dmaReq` is due one edge after its cause. The bench drives inputs one time unit after the rising edge. A behavioural model steps on each rising edge, and all four outputs are compared with the model at every falling edge, so both the registered result and the combinational results have settled. The directed scenarios count the edges explicitly for the re-request case and the same-edge conflict case, where the request is low for one cycle and then rises again.

// File: rtl/flag_req_pkg.sv
package flag_req_pkg;
  localparam int FLAG_COUNT = 5;

  typedef enum logic [2:0] {
    FL_TX_EMPTY = 3'd0,
    FL_TX_DONE  = 3'd1,
    FL_RX_FULL  = 3'd2,
    FL_RX_IDLE  = 3'd3,
    FL_BREAK    = 3'd4
  } flag_idx_e;

  // strobes from control to the request register file
  typedef struct packed {
    logic [FLAG_COUNT-1:0] setReq;
    logic [FLAG_COUNT-1:0] dropReq;
    logic [FLAG_COUNT-1:0] ackHit;
  } req_strobe_t;
endpackage

// File: rtl/flag_req_ctrl.sv
module flag_req_ctrl
  import flag_req_pkg::*;
#(
  parameter int NFLAG = FLAG_COUNT,
  parameter logic [NFLAG-1:0] RX_BLOCK_MASK = 5'b01100
) (
  input  logic [NFLAG-1:0] reqEn,
  input  logic [NFLAG-1:0] dmaSel,
  input  logic [NFLAG-1:0] flagIn,
  input  logic [NFLAG-1:0] dmaDone,
  input  logic [NFLAG-1:0] reqQ,
  output req_strobe_t      strobes,
  output logic             irqOut,
  output logic [NFLAG-1:0] clrBlock
);
  logic [NFLAG-1:0] dmaMode;
  logic [NFLAG-1:0] irqMode;

  for (genvar i = 0; i < NFLAG; i++) begin : g_route
    assign dmaMode[i] = reqEn[i] & dmaSel[i];
    assign irqMode[i] = reqEn[i] & ~dmaSel[i];
    if (RX_BLOCK_MASK[i]) begin : g_rx
      assign clrBlock[i] = dmaMode[i];
    end else begin : g_tx
      assign clrBlock[i] = 1'b0;
    end
  end

  always_comb begin
    strobes.ackHit  = dmaDone & reqQ & dmaMode;
    strobes.dropReq = strobes.ackHit | ~dmaMode;
    strobes.setReq  = dmaMode & flagIn & ~strobes.dropReq;
  end

  assign irqOut = |(irqMode & flagIn);
endmodule

// File: rtl/flag_req_regs.sv
module flag_req_regs
  import flag_req_pkg::*;
#(
  parameter int NFLAG = FLAG_COUNT
) (
  input  logic             clk,
  input  logic             rst,
  input  req_strobe_t      strobes,
  output logic [NFLAG-1:0] reqQ,
  output logic [NFLAG-1:0] flagClr
);
  always_ff @(posedge clk) begin
    if (rst) reqQ <= '0;
    else     reqQ <= (reqQ & ~strobes.dropReq) | strobes.setReq;
  end

  assign flagClr = strobes.ackHit;

  // R6: a clear strobe only ever accompanies a pending request
  a_r6_clr_needs_req: assert property (@(posedge clk) disable iff (rst)
    (flagClr & ~reqQ) == '0);

  // R5: an acknowledged channel is idle after the edge
  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (flagClr != '0) |=> ((reqQ & $past(flagClr)) == '0));
endmodule

// File: rtl/flag_req_router.sv
module flag_req_router
  import flag_req_pkg::*;
#(
  parameter logic [FLAG_COUNT-1:0] RX_BLOCK_MASK = 5'b01100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FLAG_COUNT-1:0] reqEn,
  input  logic [FLAG_COUNT-1:0] dmaSel,
  input  logic [FLAG_COUNT-1:0] flagIn,
  input  logic [FLAG_COUNT-1:0] dmaDone,
  output logic [FLAG_COUNT-1:0] dmaReq,
  output logic                  irqOut,
  output logic [FLAG_COUNT-1:0] flagClr,
  output logic [FLAG_COUNT-1:0] clrBlock
);
  req_strobe_t strobes;

  flag_req_ctrl #(.NFLAG(FLAG_COUNT), .RX_BLOCK_MASK(RX_BLOCK_MASK)) u_ctrl (
    .reqEn(reqEn), .dmaSel(dmaSel), .flagIn(flagIn), .dmaDone(dmaDone),
    .reqQ(dmaReq), .strobes(strobes), .irqOut(irqOut), .clrBlock(clrBlock)
  );

  flag_req_regs #(.NFLAG(FLAG_COUNT)) u_regs (
    .clk(clk), .rst(rst), .strobes(strobes), .reqQ(dmaReq), .flagClr(flagClr)
  );

  // R2: no request on a channel that was not routed to DMA
  a_r2_no_req_unrouted: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((dmaReq & ~$past(reqEn & dmaSel)) == '0));

  // R1: a new request needs a routed, raised flag at the edge before
  a_r1_rise_needs_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((dmaReq & ~$past(dmaReq) & ~$past(flagIn & reqEn & dmaSel)) == '0));

  // R4: a routed request only falls after a done pulse
  a_r4_hold_until_done: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(dmaReq) & ~dmaReq & ~$past(dmaDone) & $past(reqEn & dmaSel)) == '0));

  // R9: reset leaves no request
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (dmaReq == '0));
endmodule

// File: tb/flag_req_router_bench.sv
module flag_req_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] reqEn = '0, dmaSel = '0, flagIn = '0, dmaDone = '0;
  logic [N-1:0] dmaReq, flagClr, clrBlock;
  logic irqOut;

  int compared = 0;
  int mismatched = 0;
  logic [N-1:0] mReq = '0;

  flag_req_router u_flag_req_router (
    .clk(clk), .rst(rst), .reqEn(reqEn), .dmaSel(dmaSel), .flagIn(flagIn),
    .dmaDone(dmaDone), .dmaReq(dmaReq), .irqOut(irqOut), .flagClr(flagClr),
    .clrBlock(clrBlock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: one step per rising edge
  always @(posedge clk) begin
    if (rst) mReq = '0;
    else begin
      for (int i = 0; i < N; i++) begin
        if (!(reqEn[i] && dmaSel[i]))   mReq[i] = 1'b0;
        else if (dmaDone[i] && mReq[i]) mReq[i] = 1'b0;
        else if (flagIn[i])             mReq[i] = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic irqExp;
      irqExp = 1'b0;
      for (int i = 0; i < N; i++) irqExp |= flagIn[i] & reqEn[i] & ~dmaSel[i];
      chk("R1 dmaReq", dmaReq, mReq);
      chk("R3 irqOut", {4'b0, irqOut}, {4'b0, irqExp});
      chk("R5 flagClr", flagClr, dmaDone & mReq & reqEn & dmaSel);
      chk("R8 clrBlock", clrBlock, reqEn & dmaSel & 5'b01100);
    end
  end

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    step(3);
    chk("R9 reset", dmaReq, 5'b0);
    rst = 1'b0;
    step(1);
    chk("R9 after reset", dmaReq, 5'b0);

    // R1: routed receive-full flag
    reqEn = 5'b11111; dmaSel = 5'b11110;
    flagIn = 5'b00100;
    step(1);
    chk("R1 req rises", dmaReq, 5'b00100);
    // R8: block lines for the receive flags
    chk("R8 block rx", clrBlock, 5'b01100);

    // R3 / R2: flag 0 enabled but not selected
    flagIn = 5'b00101;
    #1;
    chk("R3 irq on", {4'b0, irqOut}, 5'b00001);
    step(2);
    chk("R2 no dma for irq flag", dmaReq & 5'b00001, 5'b0);

    // R4: flag drops, request holds
    flagIn = 5'b00000;
    step(3);
    chk("R4 hold", dmaReq, 5'b00100);

    // R6: done on a channel without a request
    dmaDone = 5'b00010;
    #1;
    chk("R6 no clr", flagClr, 5'b0);
    step(1);
    chk("R6 unchanged", dmaReq, 5'b00100);

    // R5: done on the pending channel
    dmaDone = 5'b00100;
    #1;
    chk("R5 clr strobe", flagClr, 5'b00100);
    step(1);
    dmaDone = '0;
    chk("R5 dropped", dmaReq, 5'b0);

    // R7 / R11: idle flag stays high across the done pulse
    flagIn = 5'b01000;
    step(1);
    chk("R7 first req", dmaReq, 5'b01000);
    dmaDone = 5'b01000;
    step(1);
    dmaDone = '0;
    chk("R11 done wins", dmaReq, 5'b0);
    step(1);
    chk("R7 re-request", dmaReq, 5'b01000);
    flagIn = '0;
    dmaDone = 5'b01000;
    step(1);
    dmaDone = '0;

    // R10: leave DMA mode while pending
    dmaSel = 5'b11111;
    flagIn = 5'b10000;
    step(1);
    flagIn = '0;
    chk("R10 pending", dmaReq, 5'b10000);
    dmaSel = 5'b01111;
    #1;
    chk("R10 no clr", flagClr, 5'b0);
    chk("R8 tx never blocks", clrBlock & 5'b10011, 5'b0);
    step(1);
    chk("R10 dropped", dmaReq, 5'b0);

    // R2: selected but not enabled
    reqEn = 5'b00000; dmaSel = 5'b11111; flagIn = 5'b11111;
    step(2);
    chk("R2 disabled", dmaReq, 5'b0);
    chk("R8 disabled", clrBlock, 5'b0);

    // mixed traffic checked against the model every cycle
    for (int c = 0; c < 400; c++) begin
      reqEn   = 5'($urandom);
      dmaSel  = 5'($urandom) | 5'($urandom);
      flagIn  = 5'($urandom);
      dmaDone = 5'($urandom) & 5'($urandom);
      step(1);
    end
    step(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule